// File: doc/BRIEF.md
# Automatic Sample-and-Convert Sequencer

This block drives a successive-approximation converter without software help. Once it is enabled with automatic sampling on, it runs a fixed cycle of phases. It holds the sample/hold switch closed for a programmed number of conversion clocks. An internal down-counter then ends the sampling phase, and the block issues a one-clock start strobe to the converter. It waits for the converter's completion and reports the result with a one-clock valid strobe that carries the channel number. It then begins sampling again at once, so capture is continuous. In this block one conversion clock period is one `clk` cycle.

The channel comes from one of two sources. With scanning off, every conversion uses the fixed channel select. With scanning on, the block walks the channels whose bit is set in a 16-bit mask, in ascending order, and wraps from the highest set channel back to the lowest. The converter is modelled inside the block as a core that raises done a fixed number of clocks (`CONV_LAT`) after its start strobe.

The sequencer has five states:
- IDLE: rest state.
- SAMPLE: the sample/hold control is high.
- LAUNCH: one cycle that carries the start strobe.
- CONVERT: waits for the core's done.
- REPORT: one cycle that carries the result-valid strobe.

The transitions are:
- IDLE→SAMPLE when enabled with automatic sampling on.
- SAMPLE→LAUNCH when the sample counter expires.
- LAUNCH→CONVERT always.
- CONVERT→REPORT on done.
- REPORT→SAMPLE when automatic sampling is still on.
- REPORT→IDLE when it is off.
- Any state→IDLE when enable is low.

Top module: `adc_autoseq`

## Requirements
- R1: After the last sampling cycle, `start_conv` is high for exactly one cycle, in the cycle right after `sample_hold` falls.
- R2: While `en` and `auto_en` are both high, `sample_hold` rises in the cycle right after each `result_valid`.
- R3: A sampling phase keeps `sample_hold` high for exactly `sample_time` cycles. A value of 0 gives 1 cycle, and the full 5-bit range up to 31 is supported.
- R4: With `scan_en` low, every result carries the channel on `fixed_sel`.
- R5: With `scan_en` high, results step through the channels whose `scan_mask` bit (bit i = channel i) is 1, in ascending order. Channels with a 0 bit are skipped, and the sequence wraps from the highest set channel to the lowest.
- R6: With `scan_en` high and `scan_mask` all zero, every result carries channel 0.
- R7: Driving `en` low forces `sample_hold` and `start_conv` low on the next clock, and no `result_valid` follows from the interrupted conversion.
- R8: With `auto_en` low, the block finishes any conversion in progress and then stays idle, with `sample_hold` low and no further results.
- R9: `result_valid` is one cycle wide, appears `CONV_LAT`+1 cycles after the cycle of `start_conv`, and `result_chan` carries the channel that was sampled.
- R10: After reset, `sample_hold`, `start_conv` and `result_valid` are low and `channel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable |
| auto_en | input | 1 | Automatic sampling enable |
| sample_time | input | 5 | Sampling length in clock periods (0 means 1) |
| scan_en | input | 1 | Channel scan enable |
| scan_mask | input | 16 | Channels taking part in a scan, bit i = channel i |
| fixed_sel | input | 4 | Channel used when scanning is off |
| channel | output | 4 | Channel currently routed to the sample/hold |
| sample_hold | output | 1 | High while sampling |
| start_conv | output | 1 | One-cycle start strobe to the converter |
| result_valid | output | 1 | One-cycle result strobe |
| result_chan | output | 4 | Channel of the reported result |

## Verification
A wrong state shows at the ports within one conversion period, at most `sample_time`+`CONV_LAT`+2 cycles. If the sample counter is off by one, the width of the `sample_hold` pulse is wrong on the first sample. A bad scan-successor calculation puts a wrong or repeated channel on the next `result_chan`. If the sequencer leaves CONVERT or REPORT at the wrong time, the spacing between `start_conv` and `result_valid` changes, or sampling fails to resume in the very next cycle. An enable that is not obeyed shows up as a strobe in the clock right after `en` falls.

// File: rtl/adc_autoseq_pkg.sv
package adc_autoseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SAMPLE  = 3'd1,
        ST_LAUNCH  = 3'd2,
        ST_CONVERT = 3'd3,
        ST_REPORT  = 3'd4
    } seq_state_t;
endpackage

// File: rtl/adc_sample_timer.sv
module adc_sample_timer #(
    parameter int STW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           run,
    input  logic [STW-1:0] sample_time,
    output logic           expire
);
    logic [STW-1:0] cnt;
    logic [STW-1:0] load_val;

    always_comb begin
        load_val = (sample_time == '0) ? STW'(1) : sample_time;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && cnt > STW'(1)) begin
            cnt <= cnt - STW'(1);
        end
    end

    assign expire = run && (cnt == STW'(1));

    AST_TIMER_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt != '0)); // R3
endmodule

// File: rtl/adc_chan_scan.sv
module adc_chan_scan #(
    parameter int NCH = 16,
    localparam int CHW = $clog2(NCH)
) (
    input  logic [NCH-1:0] mask,
    input  logic [CHW-1:0] cur,
    output logic [CHW-1:0] first,
    output logic [CHW-1:0] next
);
    logic found_first;
    logic found_next;

    always_comb begin
        first       = '0;
        found_first = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (mask[i] && !found_first) begin
                first       = CHW'(i);
                found_first = 1'b1;
            end
        end
        next       = first;
        found_next = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (mask[i] && !found_next && (CHW'(i) > cur)) begin
                next       = CHW'(i);
                found_next = 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_conv_model.sv
module adc_conv_model #(
    parameter int CONV_LAT = 12,
    localparam int CW = $clog2(CONV_LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic abort,
    input  logic start,
    output logic done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (abort) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(CONV_LAT);
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign done = (cnt == CW'(1));

    AST_DONE_NOT_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !done); // R9
endmodule

// File: rtl/adc_autoseq.sv
module adc_autoseq
    import adc_autoseq_pkg::*;
#(
    parameter int NCH      = 16,
    parameter int STW      = 5,
    parameter int CONV_LAT = 12,
    localparam int CHW     = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           auto_en,
    input  logic [STW-1:0] sample_time,
    input  logic           scan_en,
    input  logic [NCH-1:0] scan_mask,
    input  logic [CHW-1:0] fixed_sel,
    output logic [CHW-1:0] channel,
    output logic           sample_hold,
    output logic           start_conv,
    output logic           result_valid,
    output logic [CHW-1:0] result_chan
);
    seq_state_t     state, state_nxt;
    logic [CHW-1:0] chan_q, chan_nxt;
    logic [CHW-1:0] scan_first, scan_next;
    logic           timer_load, timer_expire, core_done;

    adc_chan_scan #(.NCH(NCH)) u_scan (
        .mask  (scan_mask),
        .cur   (chan_q),
        .first (scan_first),
        .next  (scan_next)
    );

    adc_sample_timer #(.STW(STW)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (timer_load),
        .run         (state == ST_SAMPLE),
        .sample_time (sample_time),
        .expire      (timer_expire)
    );

    adc_conv_model #(.CONV_LAT(CONV_LAT)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .abort (!en),
        .start (start_conv),
        .done  (core_done)
    );

    always_comb begin
        state_nxt = state;
        chan_nxt  = chan_q;
        unique case (state)
            ST_IDLE: begin
                if (auto_en) begin
                    state_nxt = ST_SAMPLE;
                    chan_nxt  = scan_en ? scan_first : fixed_sel;
                end
            end
            ST_SAMPLE:  if (timer_expire) state_nxt = ST_LAUNCH;
            ST_LAUNCH:  state_nxt = ST_CONVERT;
            ST_CONVERT: if (core_done) state_nxt = ST_REPORT;
            ST_REPORT: begin
                if (auto_en) begin
                    state_nxt = ST_SAMPLE;
                    chan_nxt  = scan_en ? scan_next : fixed_sel;
                end else begin
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
        if (!en) begin
            state_nxt = ST_IDLE;
            chan_nxt  = chan_q;
        end
    end

    assign timer_load = (state != ST_SAMPLE) && (state_nxt == ST_SAMPLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            chan_q <= '0;
        end else begin
            state  <= state_nxt;
            chan_q <= chan_nxt;
        end
    end

    always_comb begin
        sample_hold  = (state == ST_SAMPLE);
        start_conv   = (state == ST_LAUNCH);
        result_valid = (state == ST_REPORT);
        channel      = chan_q;
        result_chan  = chan_q;
    end

    AST_START_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_conv |-> $past(sample_hold)); // R1
    AST_START_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        start_conv |=> !start_conv); // R1
    AST_AUTO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && en && auto_en) |=> sample_hold); // R2
    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sample_hold && !start_conv && !result_valid)); // R7
    AST_VALID_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R9
endmodule

// File: tb/adc_autoseq_test.sv
module adc_autoseq_test;
    localparam int LAT = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, auto_en = 1'b0, scan_en = 1'b0;
    logic [4:0]  sample_time = 5'd0;
    logic [15:0] scan_mask = '0;
    logic [3:0]  fixed_sel = '0;
    logic [3:0]  channel, result_chan;
    logic        sample_hold, start_conv, result_valid;
    int          errors = 0, checks = 0;

    always #5 clk = ~clk;

    adc_autoseq #(.CONV_LAT(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .auto_en(auto_en),
        .sample_time(sample_time), .scan_en(scan_en), .scan_mask(scan_mask),
        .fixed_sel(fixed_sel), .channel(channel), .sample_hold(sample_hold),
        .start_conv(start_conv), .result_valid(result_valid),
        .result_chan(result_chan)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic stop_all();
        en = 1'b0; auto_en = 1'b0;
        step(); step();
    endtask

    task automatic next_result(output int ch, output int ok);
        ok = 0; ch = -1;
        for (int i = 0; i < 200; i++) begin
            step();
            if (result_valid) begin ok = 1; ch = result_chan; break; end
        end
    endtask

    task automatic t_reset();
        check("R10 sample_hold", sample_hold, 0);
        check("R10 start_conv", start_conv, 0);
        check("R10 result_valid", result_valid, 0);
        check("R10 channel", channel, 0);
    endtask

    task automatic t_timing(input int st, input int sel);
        int n = 0, k = 0, exp_n;
        exp_n = (st == 0) ? 1 : st;
        sample_time = 5'(st); fixed_sel = 4'(sel); scan_en = 1'b0;
        en = 1'b1; auto_en = 1'b1;
        step();
        while (sample_hold && n < 100) begin n++; step(); end
        check("R3 sample length", n, exp_n);
        check("R1 start after sample", start_conv, 1);
        step(); k = 1;
        check("R1 start one wide", start_conv, 0);
        while (!result_valid && k < 100) begin k++; step(); end
        check("R9 start to valid", k, LAT + 1);
        check("R4 fixed channel", result_chan, sel);
        step();
        check("R9 valid one wide", result_valid, 0);
        check("R2 auto restart", sample_hold, 1);
        stop_all();
    endtask

    task automatic t_scan();
        int exp_ch [6] = '{1, 4, 13, 15, 1, 4};
        int ch, ok;
        scan_mask = 16'b1010_0000_0001_0010;
        scan_en = 1'b1; sample_time = 5'd2; en = 1'b1; auto_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            next_result(ch, ok);
            check("R5 scan result seen", ok, 1);
            check("R5 scan order", ch, exp_ch[i]);
        end
        stop_all();
    endtask

    task automatic t_zero_mask();
        int ch, ok;
        scan_mask = '0; scan_en = 1'b1; sample_time = 5'd1;
        en = 1'b1; auto_en = 1'b1;
        for (int i = 0; i < 2; i++) begin
            next_result(ch, ok);
            check("R6 zero mask", ch, 0);
        end
        stop_all();
    endtask

    task automatic t_auto_off();
        int ch, ok, seen = 0;
        scan_en = 1'b0; fixed_sel = 4'd9; sample_time = 5'd3;
        en = 1'b1; auto_en = 1'b1;
        while (!start_conv) step();
        auto_en = 1'b0;
        next_result(ch, ok);
        check("R8 pending result kept", ch, 9);
        for (int i = 0; i < 60; i++) begin
            step();
            if (sample_hold || result_valid) seen++;
        end
        check("R8 stays idle", seen, 0);
        stop_all();
    endtask

    task automatic t_disable();
        int seen = 0;
        scan_en = 1'b0; sample_time = 5'd31; en = 1'b1; auto_en = 1'b1;
        for (int i = 0; i < 5; i++) step();
        check("R7 sampling before disable", sample_hold, 1);
        en = 1'b0;
        step();
        check("R7 sample_hold dropped", sample_hold, 0);
        en = 1'b1; auto_en = 1'b0;
        for (int i = 0; i < 60; i++) begin
            step();
            if (result_valid || start_conv || sample_hold) seen++;
        end
        check("R7 no result after disable", seen, 0);
        stop_all();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_timing(15, 5);
        t_timing(31, 2);
        t_timing(0, 7);
        t_scan();
        t_zero_mask();
        t_auto_off();
        t_disable();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule